// File: doc/BRIEF.md
# Fractional-Rate Timestamp Clock with Snapshot

This block keeps a 64-bit time value for precision time protocol work. On every cycle of the reference clock a 32-bit rate word is added into a 32-bit phase accumulator. Each carry out of that sum advances the time value by one. The time value therefore runs at rate/2^32 of the reference frequency. For example, 0x80000000 gives half the reference rate, and 0xC0000000 gives three quarters of it.

Software reaches the block through a small synchronous register port with a write strobe, a read strobe and a 2-bit word address. The time value is never read live. A command write first copies all 64 bits into a hold register, and the two 32-bit halves are then read from that copy. A new time value is loaded by writing both halves, in either order. Nothing changes until the second half arrives, and then both halves take effect in the same cycle. The rate word can be rewritten at any moment to trim the frequency without a jump in the time value.

Top module: `tsclk_top`

## Requirements
- R1: After synchronous reset the time value, the phase accumulator, the rate word and the hold register are all zero. Every register read returns 0 until something is written.
- R2: Each cycle the rate word (address 3, read/write) is added modulo 2^32 to the accumulator. With a rate of zero the accumulator and the time value stay still.
- R3: The time value rises by exactly one in each cycle where that addition carries out, and holds in every other cycle in which no load commits.
- R4: With a rate of 0x80000000, the time value advances by exactly N over any 2N reference cycles.
- R5: A write with bit 0 set to address 0 copies the full time value into the hold register at that clock edge. Reads of address 1 return hold bits 63:32 and reads of address 2 return hold bits 31:0. The held value stays fixed until the next copy while counting continues.
- R6: Address 0 reads back as 0, and a write to address 0 with bit 0 clear has no effect.
- R7: A write to address 1 stages the high half and a write to address 2 stages the low half. The time value does not change until both halves have been staged. The halves may arrive in either order, and a repeated write to the same half replaces the staged word.
- R8: When the second half arrives, the time value takes the full 64-bit staged word at that edge, even if a carry occurs in the same cycle. Both pending marks clear, and the accumulator keeps its phase.
- R9: The time value wraps from all ones to zero.
- R10: Changing the rate word alters only later increments and leaves the current time value untouched.
- R11: A read strobe with an address returns the data on rdata at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Word address: 0 command, 1 high half, 2 low half, 3 rate |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |

## Verification
The bench checks a load that commits in the same cycle as an accumulator carry. A design that lets the increment win would return the loaded value plus one. It checks a single staged half followed by a snapshot: a design that commits each half on its own would show a half-written time value. It checks a rollover from all ones: a design that saturates, or that clears the accumulator on load, would drift from the expected count afterwards. Random mixes of rate changes, staged writes in both orders and snapshots are compared against a cycle model built from the requirements. A design whose hold register tracks the live count would miss these comparisons.

// File: rtl/ts_pkg.sv
package ts_pkg;
  typedef enum logic [1:0] {
    A_CMD  = 2'd0,
    A_HIGH = 2'd1,
    A_LOW  = 2'd2,
    A_RATE = 2'd3
  } ts_addr_e;

  localparam int SNAP_BIT = 0;
endpackage

// File: rtl/ts_rate_acc.sv
module ts_rate_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rate_wr,
  input  logic [ACC_W-1:0] rate_wdata,
  output logic [ACC_W-1:0] rate_o,
  output logic             tick_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] rate_q;
  logic [ACC_W:0]   sum;

  always_comb sum = {1'b0, acc_q} + {1'b0, rate_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      rate_q <= '0;
    end else begin
      acc_q <= sum[ACC_W-1:0];
      if (rate_wr) rate_q <= rate_wdata;
    end
  end

  assign tick_o = sum[ACC_W];
  assign rate_o = rate_q;

  // R2: a zero rate freezes the phase
  p_zero_rate_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (rate_q == '0) |=> (acc_q == $past(acc_q)));

  // R2: a zero rate never produces a carry
  p_zero_rate_tick_r2: assert property (@(posedge clk) disable iff (rst)
    (rate_q == '0) |-> !tick_o);
endmodule

// File: rtl/ts_stage.sv
module ts_stage #(
  parameter int WORD_W = 32,
  localparam int FULL_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [WORD_W-1:0] wdata,
  output logic              load_o,
  output logic [FULL_W-1:0] load_val_o
);
  logic [1:0]              wr_half;
  logic [1:0]              pend_q;
  logic [1:0][WORD_W-1:0]  stage_q;
  logic [1:0][WORD_W-1:0]  merged;
  logic                    commit;

  assign wr_half = {wr_hi, wr_lo};
  assign commit  = (wr_half[1] & pend_q[0]) | (wr_half[0] & pend_q[1]);

  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk) begin
      if (rst) begin
        stage_q[h] <= '0;
        pend_q[h]  <= 1'b0;
      end else if (commit) begin
        pend_q[h] <= 1'b0;
      end else if (wr_half[h]) begin
        stage_q[h] <= wdata;
        pend_q[h]  <= 1'b1;
      end
    end
    assign merged[h] = wr_half[h] ? wdata : stage_q[h];
  end

  assign load_o     = commit;
  assign load_val_o = {merged[1], merged[0]};

  // R8: both pending marks clear after a commit
  p_pend_clear_r8: assert property (@(posedge clk) disable iff (rst)
    commit |=> (pend_q == 2'b00));

  // R7: a commit needs one half already staged
  p_commit_needs_pend_r7: assert property (@(posedge clk) disable iff (rst)
    commit |-> (pend_q != 2'b00));
endmodule

// File: rtl/ts_counter.sv
module ts_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             snap_i,
  output logic [CNT_W-1:0] snap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] snap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      snap_q <= '0;
    end else begin
      if (load_i)      cnt_q <= load_val_i;
      else if (tick_i) cnt_q <= cnt_q + 1'b1;
      if (snap_i)      snap_q <= cnt_q;
    end
  end

  assign snap_o = snap_q;

  // R3: exactly one step per carry
  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!load_i && tick_i) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R3: hold without a carry
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !tick_i) |=> $stable(cnt_q));

  // R8: a load beats a same-cycle carry
  p_load_wins_r8: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cnt_q == $past(load_val_i)));

  // R5: the hold register takes the pre-edge count
  p_snap_copy_r5: assert property (@(posedge clk) disable iff (rst)
    snap_i |=> (snap_q == $past(cnt_q)));

  // R5: the held value stays put between copies
  p_snap_keep_r5: assert property (@(posedge clk) disable iff (rst)
    !snap_i |=> $stable(snap_q));
endmodule

// File: rtl/tsclk_top.sv
module tsclk_top
  import ts_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int CNT_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  logic              rate_wr, wr_hi, wr_lo, snap_req, tick, load;
  logic [WORD_W-1:0] rate;
  logic [CNT_W-1:0]  load_val, snap;
  logic [WORD_W-1:0] rd_mux;
  ts_addr_e          a;

  assign a        = ts_addr_e'(addr);
  assign rate_wr  = wr_en && (a == A_RATE);
  assign wr_hi    = wr_en && (a == A_HIGH);
  assign wr_lo    = wr_en && (a == A_LOW);
  assign snap_req = wr_en && (a == A_CMD) && wdata[SNAP_BIT];

  ts_rate_acc #(.ACC_W(WORD_W)) u_acc (
    .clk(clk), .rst(rst), .rate_wr(rate_wr), .rate_wdata(wdata),
    .rate_o(rate), .tick_o(tick)
  );

  ts_stage #(.WORD_W(WORD_W)) u_stage (
    .clk(clk), .rst(rst), .wr_hi(wr_hi), .wr_lo(wr_lo), .wdata(wdata),
    .load_o(load), .load_val_o(load_val)
  );

  ts_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_i(tick), .load_i(load),
    .load_val_i(load_val), .snap_i(snap_req), .snap_o(snap)
  );

  always_comb begin
    unique case (a)
      A_HIGH:  rd_mux = snap[CNT_W-1:WORD_W];
      A_LOW:   rd_mux = snap[WORD_W-1:0];
      A_RATE:  rd_mux = rate;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R6: the command word always reads back as zero
  p_cmd_reads_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && a == A_CMD) |=> (rdata == '0));

  // R11: rdata only moves on a read strobe
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/tb_tsclk_top.sv
module tb_tsclk_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, rd_en;
  logic [1:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  tsclk_top dut (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
                 .addr(addr), .wdata(wdata), .rdata(rdata));

  // cycle model built from the requirements
  logic [31:0] m_acc, m_rate, m_shi, m_slo;
  logic [63:0] m_cnt, m_snap;
  logic        m_phi, m_plo;

  function automatic logic [32:0] add_carry(logic [31:0] a, logic [31:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  always @(posedge clk) begin
    logic [32:0] s;
    logic        ld;
    logic [63:0] v;
    if (rst) begin
      m_acc <= 0; m_rate <= 0; m_cnt <= 0; m_snap <= 0;
      m_shi <= 0; m_slo <= 0; m_phi <= 0; m_plo <= 0;
    end else begin
      s  = add_carry(m_acc, m_rate);
      ld = wr_en && ((addr == 2'd1 && m_plo) || (addr == 2'd2 && m_phi));
      v  = {(wr_en && addr == 2'd1) ? wdata : m_shi,
            (wr_en && addr == 2'd2) ? wdata : m_slo};
      m_acc <= s[31:0];
      if (wr_en && addr == 2'd3) m_rate <= wdata;
      if (wr_en && addr == 2'd0 && wdata[0]) m_snap <= m_cnt;
      if (ld) begin
        m_cnt <= v; m_phi <= 0; m_plo <= 0;
      end else begin
        if (s[32]) m_cnt <= m_cnt + 1;
        if (wr_en && addr == 2'd1) begin m_shi <= wdata; m_phi <= 1; end
        if (wr_en && addr == 2'd2) begin m_slo <= wdata; m_plo <= 1; end
      end
    end
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
    d = rdata;
  endtask

  // copy then read both halves; copy edges of back-to-back calls are 3 apart
  task automatic snap_read(output logic [63:0] v);
    logic [31:0] h, l;
    wr(2'd0, 32'h1);
    rd(2'd1, h);
    rd(2'd2, l);
    v = {h, l};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] v, v2;
    logic [31:0] d;
    int          unused_seed;
    unused_seed = $urandom(32'h5eed_1588);
    rst = 1; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    idle(3);
    rst = 0;
    idle(1);

    // R1 reset state
    rd(2'd3, d);   check("R1 rate after reset", {32'h0, d}, 64'h0);
    idle(10);
    snap_read(v);  check("R1 time after reset (R2 zero rate)", v, 64'h0);

    // R6 command reads zero, and bit 0 clear does not copy
    rd(2'd0, d);   check("R6 cmd read", {32'h0, d}, 64'h0);
    wr(2'd3, 32'h8000_0000);
    idle(20);
    wr(2'd0, 32'hFFFF_FFFE);
    rd(2'd1, d);   check("R6 no copy high", {32'h0, d}, 64'h0);
    rd(2'd2, d);   check("R6 no copy low", {32'h0, d}, 64'h0);

    // R11 read latency on rate word
    rd(2'd3, d);   check("R11 rate readback", {32'h0, d}, 64'h8000_0000);

    // R4 half rate: copy edges 40 apart give exactly 20
    snap_read(v);
    idle(37);
    snap_read(v2);
    check("R4 half rate increments", v2 - v, 64'd20);
    check("R3 model match", v2, m_snap);

    // R7 single half leaves time unchanged
    wr(2'd3, 32'h0);
    snap_read(v);
    wr(2'd1, 32'h1234_5678);
    snap_read(v2); check("R7 one half no change", v2, v);
    wr(2'd1, 32'h0BAD_F00D);
    wr(2'd2, 32'h9ABC_DEF0);
    snap_read(v2); check("R7 hi then lo commit", v2, 64'h0BAD_F00D_9ABC_DEF0);
    wr(2'd2, 32'h1111_2222);
    wr(2'd1, 32'h3333_4444);
    snap_read(v2); check("R7 lo then hi commit", v2, 64'h3333_4444_1111_2222);

    // R8 load against carry on both phases of a half rate
    wr(2'd3, 32'h8000_0000);
    for (int k = 0; k < 2; k++) begin
      wr(2'd1, 32'h0000_00AA);
      idle(k);
      wr(2'd2, 32'h0000_0055);
      snap_read(v);  check("R8 load vs carry", v, m_snap);
      check("R8 load value kept", v - 64'h0000_00AA_0000_0055, m_snap - 64'h0000_00AA_0000_0055);
    end

    // R9 wrap from all ones
    wr(2'd3, 32'hFFFF_FFFF);
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd1, 32'hFFFF_FFFF);
    idle(5);
    snap_read(v);  check("R9 wrap to small value", {63'h0, v < 64'd16}, 64'h1);
    check("R9 wrap model", v, m_snap);

    // R10 rate change keeps value continuous
    wr(2'd3, 32'hC000_0000);
    snap_read(v);  check("R10 after rate change", v, m_snap);
    wr(2'd3, 32'h547A_E147);
    idle(50);
    snap_read(v2); check("R10 slowed rate", v2, m_snap);

    // R5 held value stays fixed while counting continues
    snap_read(v);
    idle(30);
    rd(2'd1, d);   check("R5 held high stable", {32'h0, d}, {32'h0, v[63:32]});
    rd(2'd2, d);   check("R5 held low stable", {32'h0, d}, {32'h0, v[31:0]});

    // random mix, R2 R3 R5 R7 R8 R10 R11 against the model
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 6);
      case (op)
        0: begin
          case ($urandom_range(0, 4))
            0: wr(2'd3, 32'h547A_E147);
            1: wr(2'd3, 32'h8000_0000);
            2: wr(2'd3, 32'hA8F5_C28F);
            3: wr(2'd3, 32'hE666_6666);
            default: wr(2'd3, $urandom);
          endcase
        end
        1: wr(2'd1, $urandom);
        2: wr(2'd2, $urandom);
        3: begin snap_read(v); check("R5 random copy", v, m_snap); end
        4: begin rd(2'd3, d); check("R11 random rate read", {32'h0, d}, {32'h0, m_rate}); end
        5: begin rd(2'd0, d); check("R6 random cmd read", {32'h0, d}, 64'h0); end
        default: idle($urandom_range(1, 9));
      endcase
    end
    snap_read(v);  check("R3 final model match", v, m_snap);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule